// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block carries out the processor side of an interrupt acknowledge. It compares a pending request level (1 to 7, with 0 meaning no request) against the current interrupt mask. When the request qualifies, it starts a CPU-space bus cycle: it raises an address strobe and drives a fixed address pattern that carries the acknowledged level. The cycle then ends in one of three ways. A responder supplies a vector byte together with a data-size acknowledge, a responder raises the autovector strobe, or the cycle ends in a bus error. The bus error can come from outside or from the block's own bus monitor when nothing answers in time.

From the way the cycle ended, the block works out the final vector number and the vector table address (vector base plus four times the vector). It reports the mask value to load, which is the acknowledged level. All of these appear on registered outputs together with a one-cycle completion pulse. The caller fetches the handler address from the vector table itself.

Top module: `irq_ack_seq`

## Requirements
- R1: An acknowledge cycle starts (address strobe rises one clock after the request is sampled while idle) only when the level is nonzero and is either greater than the mask or equal to 7. Any other level/mask pair leaves the strobe low.
- R2: While the strobe is high, bus address bits 23:4 are all ones, bits 3:1 hold the acknowledged level, and bit 0 is one.
- R3: When the data-size acknowledge is sampled high, with neither bus error nor autovector high, the vector number is the 8-bit data bus value and the source code is 0 (supplied).
- R4: When the autovector input is sampled high and there is no bus error, the vector number is 24 plus the level and the source code is 1 (auto). The data bus and the data-size acknowledge are ignored.
- R5: When the bus error input is sampled high, the vector number is 24 and the source code is 2 (spurious), whatever the other termination inputs are.
- R6: If no termination arrives, the internal monitor ends the cycle after the strobe has been high for TIMEOUT clocks (default 64). The vector number is then 24, the source code is 2, and the timeout flag is 1. The timeout flag is 0 for every other termination.
- R7: The vector address equals the vector base input plus the vector number times four.
- R8: At completion, the new-mask output equals the acknowledged level.
- R9: Completion is a one-clock pulse in the clock after the termination is sampled. The strobe is low during that pulse, and the address stays stable for the whole strobe.
- R10: After reset the strobe, completion pulse and busy flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_level | input | 3 | Pending request level, 0 means none |
| cur_mask | input | 3 | Current interrupt mask |
| vbr | input | 32 | Vector table base address |
| dsack_i | input | 1 | Data-size acknowledge from responder |
| avec_i | input | 1 | Autovector strobe from responder |
| berr_i | input | 1 | External bus error |
| data_i | input | 8 | Vector byte from responder |
| as_o | output | 1 | Address strobe of the acknowledge cycle |
| addr_o | output | 24 | CPU-space address |
| busy_o | output | 1 | Sequencer not idle |
| done_o | output | 1 | One-clock completion pulse |
| vec_num_o | output | 8 | Resolved vector number |
| vec_addr_o | output | 32 | Vector table entry address |
| src_o | output | 2 | Resolution: 0 supplied, 1 auto, 2 spurious |
| timeout_o | output | 1 | Cycle ended by the internal monitor |
| new_mask_o | output | 3 | Mask value to load |

## Verification
A wrongly latched level shows at once on address bits 3:1, one clock after acceptance. The same error shows two clocks later in the autovector number, the vector address and the new mask. A wrong termination priority or resolution shows up in the single completion clock as a wrong source code or vector number. A bus monitor count that is off shows as a strobe width other than TIMEOUT clocks. A state machine that sticks shows as a missing or stretched completion pulse, or as a strobe that never drops.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int LVL_W     = 3;
  localparam int BUS_AW    = 24;
  localparam int VEC_W     = 8;
  localparam int SPUR_VEC  = 24;
  localparam int AUTO_BASE = 24;

  typedef enum logic [1:0] {
    SRC_SUPPLIED = 2'd0,
    SRC_AUTO     = 2'd1,
    SRC_SPUR     = 2'd2
  } vec_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CYCLE = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_e;

  function automatic logic [BUS_AW-1:0] ack_address(input logic [LVL_W-1:0] lvl);
    ack_address = {{(BUS_AW-LVL_W-1){1'b1}}, lvl, 1'b1};
  endfunction
endpackage

// File: rtl/irq_accept_gate.sv
module irq_accept_gate #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic             accept_o
);
  localparam logic [LVL_W-1:0] TOP_LVL = '1;

  logic nonzero;
  logic above;
  logic is_top;

  always_comb begin
    nonzero  = (level_i != '0);
    above    = (level_i > mask_i);
    is_top   = (level_i == TOP_LVL);
    accept_o = nonzero && (above || is_top);
  end
endmodule

// File: rtl/irq_bus_monitor.sv
module irq_bus_monitor #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb expired_o = run_i && (cnt == LAST);

  AST_MON_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt <= LAST)); // R6
  AST_MON_SINGLE_FIRE: assert property (@(posedge clk) disable iff (rst)
    expired_o |=> !expired_o); // R6
endmodule

// File: rtl/irq_vec_resolver.sv
module irq_vec_resolver
  import irq_ack_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [LVL_W-1:0]  level_i,
  input  vec_src_e          kind_i,
  input  logic [VEC_W-1:0]  data_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic [ADDR_W-1:0] vaddr_o
);
  localparam logic [VEC_W-1:0] SPUR_V = VEC_W'(SPUR_VEC);
  localparam logic [VEC_W-1:0] AUTO_B = VEC_W'(AUTO_BASE);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    unique case (kind_i)
      SRC_SUPPLIED: vec_o = data_i;
      SRC_AUTO:     vec_o = AUTO_B + VEC_W'(level_i);
      default:      vec_o = SPUR_V;
    endcase
    offset  = ADDR_W'(vec_o) << 2;
    vaddr_o = base_i + offset;
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_ack_pkg::*;
#(
  parameter int TIMEOUT = 64,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        req_level,
  input  logic [2:0]        cur_mask,
  input  logic [ADDR_W-1:0] vbr,
  input  logic              dsack_i,
  input  logic              avec_i,
  input  logic              berr_i,
  input  logic [7:0]        data_i,
  output logic              as_o,
  output logic [23:0]       addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        vec_num_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [1:0]        src_o,
  output logic              timeout_o,
  output logic [2:0]        new_mask_o
);
  seq_state_e        state;
  logic [LVL_W-1:0]  lvl_q;
  logic              accept;
  logic              expired;
  logic              term;
  vec_src_e          kind;
  logic [VEC_W-1:0]  res_vec;
  logic [ADDR_W-1:0] res_addr;

  irq_accept_gate #(.LVL_W(LVL_W)) gate_i (
    .level_i (req_level),
    .mask_i  (cur_mask),
    .accept_o(accept)
  );

  irq_bus_monitor #(.TIMEOUT(TIMEOUT)) mon_i (
    .clk      (clk),
    .rst      (rst),
    .run_i    (state == ST_CYCLE),
    .expired_o(expired)
  );

  // bus error (external or monitor) outranks autovector, which outranks data
  always_comb begin
    term = berr_i || expired || avec_i || dsack_i;
    if (berr_i || expired) kind = SRC_SPUR;
    else if (avec_i)       kind = SRC_AUTO;
    else                   kind = SRC_SUPPLIED;
  end

  irq_vec_resolver #(.ADDR_W(ADDR_W)) res_i (
    .level_i(lvl_q),
    .kind_i (kind),
    .data_i (data_i),
    .base_i (vbr),
    .vec_o  (res_vec),
    .vaddr_o(res_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      lvl_q      <= '0;
      as_o       <= 1'b0;
      addr_o     <= '0;
      done_o     <= 1'b0;
      vec_num_o  <= '0;
      vec_addr_o <= '0;
      src_o      <= 2'd0;
      timeout_o  <= 1'b0;
      new_mask_o <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          done_o <= 1'b0;
          if (accept) begin
            lvl_q  <= req_level;
            addr_o <= ack_address(req_level);
            as_o   <= 1'b1;
            state  <= ST_CYCLE;
          end
        end
        ST_CYCLE: begin
          if (term) begin
            as_o       <= 1'b0;
            done_o     <= 1'b1;
            vec_num_o  <= res_vec;
            vec_addr_o <= res_addr;
            src_o      <= kind;
            timeout_o  <= expired && !berr_i;
            new_mask_o <= lvl_q;
            state      <= ST_DONE;
          end
        end
        default: begin
          done_o <= 1'b0;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb busy_o = (state != ST_IDLE);

  AST_ACCEPT_RULE: assert property (@(posedge clk) disable iff (rst)
    $rose(as_o) |-> (addr_o[3:1] == $past(req_level)) &&
      (($past(req_level) > $past(cur_mask)) || ($past(req_level) == 3'd7))); // R1
  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (rst)
    as_o |-> (addr_o[23:4] == 20'hFFFFF) && addr_o[0]); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (as_o && $past(as_o)) |-> $stable(addr_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!as_o && $past(as_o))); // R9
  AST_MASK_IS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (new_mask_o == $past(addr_o[3:1]))); // R8
  AST_SPUR_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (done_o && (src_o == 2'd2)) |-> (vec_num_o == 8'd24)); // R5
endmodule

// File: tb/irq_ack_seq_tb.sv
module irq_ack_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  req_level = '0;
  logic [2:0]  cur_mask = '0;
  logic [31:0] vbr = '0;
  logic        dsack_i = 1'b0;
  logic        avec_i = 1'b0;
  logic        berr_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        as_o;
  logic [23:0] addr_o;
  logic        busy_o;
  logic        done_o;
  logic [7:0]  vec_num_o;
  logic [31:0] vec_addr_o;
  logic [1:0]  src_o;
  logic        timeout_o;
  logic [2:0]  new_mask_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ack_seq #(.TIMEOUT(TMO), .ADDR_W(32)) dut_i (
    .clk(clk), .rst(rst), .req_level(req_level), .cur_mask(cur_mask), .vbr(vbr),
    .dsack_i(dsack_i), .avec_i(avec_i), .berr_i(berr_i), .data_i(data_i),
    .as_o(as_o), .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o),
    .vec_num_o(vec_num_o), .vec_addr_o(vec_addr_o), .src_o(src_o),
    .timeout_o(timeout_o), .new_mask_o(new_mask_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // mode: 0 data-size ack, 1 autovector (with dsack too), 2 bus error (with avec), 3 none
  task automatic run_ack(input logic [2:0] lvl, input logic [2:0] msk, input int mode,
                         input logic [7:0] dat, input logic [31:0] base, input int dly);
    int strobe_cnt;
    logic [7:0] exp_vec;
    logic [1:0] exp_src;
    @(negedge clk);
    req_level = lvl; cur_mask = msk; vbr = base; data_i = dat;
    @(negedge clk);
    check(as_o == 1'b1, "R1 strobe on accept", {31'd0, as_o}, 32'd1);
    check(addr_o == {20'hFFFFF, lvl, 1'b1}, "R2 address", {8'd0, addr_o}, {8'd0, 20'hFFFFF, lvl, 1'b1});
    req_level = '0;
    strobe_cnt = 1;
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      if (as_o) strobe_cnt++;
    end
    if (mode == 0) dsack_i = 1'b1;
    if (mode == 1) begin avec_i = 1'b1; dsack_i = 1'b1; end
    if (mode == 2) begin berr_i = 1'b1; avec_i = 1'b1; end
    if (mode == 3) begin
      while (!done_o && strobe_cnt < TMO + 4) begin
        @(negedge clk);
        if (as_o) strobe_cnt++;
      end
      check(strobe_cnt == TMO, "R6 strobe width", strobe_cnt, TMO);
    end else begin
      @(negedge clk);
    end
    exp_vec = (mode == 0) ? dat : (mode == 1) ? 8'(24 + lvl) : 8'd24;
    exp_src = (mode == 0) ? 2'd0 : (mode == 1) ? 2'd1 : 2'd2;
    check(done_o == 1'b1, "R9 done pulse", {31'd0, done_o}, 32'd1);
    check(as_o == 1'b0, "R9 strobe low at done", {31'd0, as_o}, 32'd0);
    check(vec_num_o == exp_vec,
          (mode == 0) ? "R3 supplied vector" : (mode == 1) ? "R4 autovector" : "R5 spurious vector",
          {24'd0, vec_num_o}, {24'd0, exp_vec});
    check(src_o == exp_src, "R3 R4 R5 source code", {30'd0, src_o}, {30'd0, exp_src});
    check(timeout_o == (mode == 3), "R6 timeout flag", {31'd0, timeout_o}, (mode == 3) ? 32'd1 : 32'd0);
    check(vec_addr_o == base + 32'(exp_vec) * 4, "R7 vector address", vec_addr_o, base + 32'(exp_vec) * 4);
    check(new_mask_o == lvl, "R8 new mask", {29'd0, new_mask_o}, {29'd0, lvl});
    dsack_i = 1'b0; avec_i = 1'b0; berr_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R9 done one clock", {31'd0, done_o}, 32'd0);
  endtask

  task automatic run_reject(input logic [2:0] lvl, input logic [2:0] msk);
    @(negedge clk);
    req_level = lvl; cur_mask = msk;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(as_o == 1'b0 && busy_o == 1'b0, "R1 no cycle when not above mask", {31'd0, as_o}, 32'd0);
    end
    req_level = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(as_o == 1'b0 && done_o == 1'b0 && busy_o == 1'b0, "R10 reset state",
          {29'd0, as_o, done_o, busy_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(as_o == 1'b0 && busy_o == 1'b0, "R10 idle after reset", {30'd0, as_o, busy_o}, 32'd0);
    for (int m = 0; m < 8; m++) begin
      for (int l = 0; l < 8; l++) begin
        if (l != 0 && (l > m || l == 7))
          run_ack(3'(l), 3'(m), (l + m) % 3, 8'(8'h40 + l * 8 + m),
                  32'h0001_0000 * m + 32'h100 * l, (l + m) % 4);
        else
          run_reject(3'(l), 3'(m));
      end
    end
    run_ack(3'd5, 3'd1, 3, 8'hA5, 32'h0000_8000, 0);
    run_ack(3'd7, 3'd7, 3, 8'h33, 32'hFFFF_FF00, 0);
    run_ack(3'd2, 3'd0, 0, 8'hFF, 32'h0, 0);
    run_ack(3'd3, 3'd2, 2, 8'h11, 32'h400, 5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule